// File: doc/BRIEF.md
# Seconds Counter with Alarm Match

This peripheral keeps elapsed time as a 32-bit seconds count. An up-counter and a mirrored down-counter move by one on each pulse of a one-second tick input. Two compare words are checked against the value the up-counter is about to take. A hit latches a sticky status flag. The flags drive an interrupt line and a power-on switch output.

Software reaches the block through a plain single-cycle register bus of 32-bit words with byte addresses. Read data is combinational from the addressed register.

A control word does several things. It pauses counting so that both counters can be reloaded safely. It holds both counters at zero during a soft reset. It gates the interrupt and selects which compare hits drive the switch output. A free 32-bit key word lets firmware mark the block as already set up. Firmware normally uses 0xB5C13F27 for this, and the hardware gives that value no meaning.

Top module: `sec_alarm_timer`

## Requirements
- R1: After reset the counters, control, status and key read 0, both compare words read 0xFFFFFFFF, and `irq_o` and `onsw_o` are low.
- R2: Word map by byte address: 0x00 up-count, 0x04 down-count, 0x08 compare 0, 0x0C compare 1, 0x10 control, 0x14 status, 0x18 key. Any other address, including a misaligned one, reads 0 and ignores writes. Control bit 5 always reads 0. The key returns the last word written.
- R3: A tick while counting is enabled adds 1 to the up-counter and subtracts 1 from the down-counter. The up-counter wraps from 0xFFFFFFFF to 0, and the down-counter wraps from 0 to 0xFFFFFFFF.
- R4: While control bit 6 (halt) is 1, ticks change neither counter.
- R5: While control bit 4 (soft reset) is 1, both counters are held at 0, and ticks and counter writes have no effect.
- R6: A tick that brings the up-counter to compare value i sets status bit i (bit 0 for compare 0, bit 1 for compare 1), whatever the enables are. The bit stays set on later ticks.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A hit in the same cycle as a clear leaves the bit set.
- R8: `irq_o` is high exactly when status bit 0 and control bit 0 are both 1. Clearing control bit 0 drops `irq_o` and keeps status bit 0.
- R9: Status bit 2 is set by a hit on a compare whose switch enable is set (control bit 2 for compare 0, control bit 3 for compare 1). `onsw_o` is high when control bit 7 is 1, or when status bit 0 and control bit 2 are both 1, or when status bit 1 and control bit 3 are both 1.
- R10: A counter write in the same cycle as a tick loads the written value exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per second |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 5 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed word |
| irq_o | output | 1 | Alarm interrupt |
| onsw_o | output | 1 | Power-on switch request |

## Verification
The hardest cases to reach are collisions inside a single cycle: a compare hit arriving together with a write-one-to-clear of the same flag, and a tick arriving together with a counter load.

The bench reaches both by asserting the tick in the same cycle as the bus write. It first preloads the counter to one below the compare value, so the hit lands exactly on that edge.

Wrap-around is reached by loading 0xFFFFFFFF and 0 while counting is halted, then releasing the halt and sending one tick.

// File: rtl/stc_pkg.sv
package stc_pkg;
  localparam int DW     = 32;
  localparam int AW     = 5;
  localparam int NCMP   = 2;
  localparam int NWORD  = 8;
  localparam int WSEL_W = $clog2(NWORD);
  localparam int CW     = 8;
  localparam int SW     = 3;

  // word indices (byte address / 4)
  localparam int IDX_UP   = 0;
  localparam int IDX_DN   = 1;
  localparam int IDX_CMP0 = 2;
  localparam int IDX_CTRL = 4;
  localparam int IDX_STAT = 5;
  localparam int IDX_KEY  = 6;

  // control bit positions
  localparam int CB_EN0   = 0;
  localparam int CB_SW0   = 2;
  localparam int CB_SRST  = 4;
  localparam int CB_HALT  = 6;
  localparam int CB_FORCE = 7;
  localparam logic [CW-1:0] CTRL_MASK = 8'hDF;

  // status bit positions
  localparam int SB_SWEV = 2;
endpackage

// File: rtl/stc_counters.sv
module stc_counters
  import stc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          srst,
  input  logic          ld_up,
  input  logic          ld_dn,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] up_q,
  output logic [DW-1:0] dn_q
);
  logic [DW-1:0] up_d, dn_d;

  always_comb begin
    up_d = up_q;
    dn_d = dn_q;
    if (srst) begin
      up_d = '0;
      dn_d = '0;
    end else begin
      if (ld_up)      up_d = wdata;
      else if (step)  up_d = up_q + 1'b1;
      if (ld_dn)      dn_d = wdata;
      else if (step)  dn_d = dn_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= '0;
      dn_q <= '0;
    end else begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !srst && !ld_up) |=> up_q == $past(up_q) + 1'b1); // R3
  AST_CNT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !srst && !ld_dn) |=> dn_q == $past(dn_q) - 1'b1); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !srst && !ld_up && !ld_dn) |=> ($stable(up_q) && $stable(dn_q))); // R4
  AST_SRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (up_q == '0 && dn_q == '0)); // R5
endmodule

// File: rtl/stc_compare.sv
module stc_compare
  import stc_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      step,
  input  logic                      ld_up,
  input  logic [DW-1:0]             up_q,
  input  logic [NCMP-1:0][DW-1:0]   cmp_q,
  output logic [NCMP-1:0]           hit
);
  logic [DW-1:0] up_next;
  assign up_next = up_q + 1'b1;

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    assign hit[i] = step && !ld_up && (up_next == cmp_q[i]);
  end

  AST_HIT_REACH: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> up_q == $past(cmp_q[0])); // R6
endmodule

// File: rtl/stc_regfile.sv
module stc_regfile
  import stc_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NWORD-1:0]          wr_sel,
  input  logic [DW-1:0]             wdata,
  input  logic [NCMP-1:0]           hit,
  output logic [CW-1:0]             ctrl_q,
  output logic [NCMP-1:0][DW-1:0]   cmp_q,
  output logic [DW-1:0]             key_q,
  output logic [SW-1:0]             stat_q
);
  logic [CW-1:0]           ctrl_d;
  logic [DW-1:0]           key_d;
  logic [SW-1:0]           stat_d;
  logic [NCMP-1:0][DW-1:0] cmp_d;
  logic [NCMP-1:0]         sw_en;
  logic [SW-1:0]           clr;

  assign sw_en = ctrl_q[CB_SW0 +: NCMP];
  assign clr   = wr_sel[IDX_STAT] ? wdata[SW-1:0] : '0;

  always_comb begin
    ctrl_d = wr_sel[IDX_CTRL] ? (wdata[CW-1:0] & CTRL_MASK) : ctrl_q;
    key_d  = wr_sel[IDX_KEY]  ? wdata : key_q;
    stat_d = stat_q & ~clr;
    stat_d[NCMP-1:0] = stat_d[NCMP-1:0] | hit;
    if (|(hit & sw_en)) stat_d[SB_SWEV] = 1'b1;
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_cmpreg
    assign cmp_d[i] = wr_sel[IDX_CMP0 + i] ? wdata : cmp_q[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp_q[i] <= '1;
      else        cmp_q[i] <= cmp_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      key_q  <= '0;
      stat_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      key_q  <= key_d;
      stat_q <= stat_d;
    end
  end

  AST_HIT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> stat_q[0]); // R6
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[0] && !(wr_sel[IDX_STAT] && wdata[0])) |=> stat_q[0]); // R7
endmodule

// File: rtl/sec_alarm_timer.sv
module sec_alarm_timer
  import stc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          onsw_o
);
  logic [1:0]              rst_sync;
  logic                    rst_core_n;
  logic [WSEL_W-1:0]       wsel;
  logic                    aligned;
  logic [NWORD-1:0]        wr_sel;
  logic [CW-1:0]           ctrl_q;
  logic [NCMP-1:0][DW-1:0] cmp_q;
  logic [DW-1:0]           key_q, up_q, dn_q;
  logic [SW-1:0]           stat_q;
  logic [NCMP-1:0]         hit;
  logic                    srst, step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  assign wsel    = addr_i[AW-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  for (genvar w = 0; w < NWORD; w++) begin : g_dec
    assign wr_sel[w] = req_i && we_i && aligned && (wsel == WSEL_W'(w));
  end

  assign srst = ctrl_q[CB_SRST];
  assign step = tick_i && !ctrl_q[CB_HALT] && !srst;

  stc_regfile u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_sel(wr_sel), .wdata(wdata_i),
    .hit(hit), .ctrl_q(ctrl_q), .cmp_q(cmp_q), .key_q(key_q), .stat_q(stat_q)
  );

  stc_counters u_cnt (
    .clk(clk), .rst_n(rst_core_n), .step(step), .srst(srst),
    .ld_up(wr_sel[IDX_UP]), .ld_dn(wr_sel[IDX_DN]), .wdata(wdata_i),
    .up_q(up_q), .dn_q(dn_q)
  );

  stc_compare u_cmp (
    .clk(clk), .rst_n(rst_core_n), .step(step), .ld_up(wr_sel[IDX_UP]),
    .up_q(up_q), .cmp_q(cmp_q), .hit(hit)
  );

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      case (wsel)
        WSEL_W'(IDX_UP):       rdata_o = up_q;
        WSEL_W'(IDX_DN):       rdata_o = dn_q;
        WSEL_W'(IDX_CMP0):     rdata_o = cmp_q[0];
        WSEL_W'(IDX_CMP0 + 1): rdata_o = cmp_q[1];
        WSEL_W'(IDX_CTRL):     rdata_o = DW'(ctrl_q);
        WSEL_W'(IDX_STAT):     rdata_o = DW'(stat_q);
        WSEL_W'(IDX_KEY):      rdata_o = key_q;
        default:               rdata_o = '0;
      endcase
    end
  end

  assign irq_o  = stat_q[0] && ctrl_q[CB_EN0];
  assign onsw_o = ctrl_q[CB_FORCE] || (|(stat_q[NCMP-1:0] & ctrl_q[CB_SW0 +: NCMP]));

  AST_IRQ_ON_HIT: assert property (@(posedge clk) disable iff (!rst_core_n)
    (hit[0] && ctrl_q[CB_EN0] && !wr_sel[IDX_CTRL]) |=> irq_o); // R8
  AST_ONSW_ON_HIT: assert property (@(posedge clk) disable iff (!rst_core_n)
    (hit[0] && ctrl_q[CB_SW0] && !wr_sel[IDX_CTRL]) |=> onsw_o); // R9
endmodule

// File: tb/tb_sec_alarm_timer.sv
`timescale 1ns/1ps
module tb_sec_alarm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0, req_i = 1'b0, we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, onsw_o;
  int          errs = 0, total = 0;

  always #2.5 clk = ~clk;

  sec_alarm_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .irq_o(irq_o), .onsw_o(onsw_o)
  );

  // entry: kind(0 write, 1 read-check, 2 tick), addr, data, requirement number
  localparam int NV = 31;
  localparam logic [42:0] VEC [NV] = '{
    {2'd0, 5'h10, 32'h0000_0040, 4'd4},  // halt
    {2'd0, 5'h00, 32'h0000_0010, 4'd2},
    {2'd0, 5'h04, 32'hFFFF_FFEF, 4'd2},
    {2'd0, 5'h08, 32'h0000_0012, 4'd2},
    {2'd0, 5'h10, 32'h0000_0005, 4'd2},
    {2'd1, 5'h10, 32'h0000_0005, 4'd2},  // R2 control readback
    {2'd2, 5'h00, 32'h0,         4'd3},
    {2'd1, 5'h00, 32'h0000_0011, 4'd3},  // R3
    {2'd1, 5'h04, 32'hFFFF_FFEE, 4'd3},  // R3
    {2'd1, 5'h14, 32'h0,         4'd6},
    {2'd2, 5'h00, 32'h0,         4'd6},  // reaches compare 0
    {2'd1, 5'h14, 32'h0000_0005, 4'd6},  // R6 and R9 switch event
    {2'd2, 5'h00, 32'h0,         4'd6},
    {2'd1, 5'h14, 32'h0000_0005, 4'd6},  // R6 sticky
    {2'd1, 5'h00, 32'h0000_0013, 4'd3},
    {2'd0, 5'h14, 32'h0000_0001, 4'd7},
    {2'd1, 5'h14, 32'h0000_0004, 4'd7},  // R7 clear one bit
    {2'd0, 5'h14, 32'h0000_0000, 4'd7},
    {2'd1, 5'h14, 32'h0000_0004, 4'd7},  // R7 zero leaves
    {2'd0, 5'h14, 32'h0000_0004, 4'd7},
    {2'd1, 5'h14, 32'h0000_0000, 4'd7},
    {2'd0, 5'h18, 32'hB5C1_3F27, 4'd2},
    {2'd1, 5'h18, 32'hB5C1_3F27, 4'd2},  // R2 key
    {2'd1, 5'h1C, 32'h0,         4'd2},  // R2 unmapped
    {2'd0, 5'h10, 32'h0000_00FF, 4'd2},
    {2'd1, 5'h10, 32'h0000_00DF, 4'd2},  // R2 bit 5 reads 0
    {2'd0, 5'h10, 32'h0000_0040, 4'd5},
    {2'd1, 5'h00, 32'h0,         4'd5},  // R5 soft reset zeroed
    {2'd1, 5'h04, 32'h0,         4'd5},
    {2'd2, 5'h00, 32'h0,         4'd4},
    {2'd1, 5'h00, 32'h0,         4'd4}   // R4 halted
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic tk = 1'b0);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d; tick_i = tk;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 v = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic tk();
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(5'h00, v); chk("R1 up", v, 32'h0);
    rd(5'h04, v); chk("R1 down", v, 32'h0);
    rd(5'h08, v); chk("R1 cmp0", v, 32'hFFFF_FFFF);
    rd(5'h0C, v); chk("R1 cmp1", v, 32'hFFFF_FFFF);
    rd(5'h10, v); chk("R1 ctrl", v, 32'h0);
    rd(5'h14, v); chk("R1 status", v, 32'h0);
    rd(5'h18, v); chk("R1 key", v, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 onsw", {31'b0, onsw_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][42:41])
        2'd0: wr(VEC[i][40:36], VEC[i][35:4]);
        2'd1: begin
          rd(VEC[i][40:36], v);
          chk($sformatf("R%0d vec %0d", VEC[i][3:0], i), v, VEC[i][35:4]);
        end
        default: tk();
      endcase
    end

    // R3 wrap
    wr(5'h00, 32'hFFFF_FFFF); wr(5'h04, 32'h0); wr(5'h10, 32'h0);
    tk();
    rd(5'h00, v); chk("R3 up wrap", v, 32'h0);
    rd(5'h04, v); chk("R3 down wrap", v, 32'hFFFF_FFFF);

    // R10 write and tick in the same cycle
    wr(5'h00, 32'h100, 1'b1);
    rd(5'h00, v); chk("R10 load wins", v, 32'h100);

    // R8 interrupt gating
    wr(5'h10, 32'h40); wr(5'h00, 32'h3); wr(5'h08, 32'h5); wr(5'h10, 32'h01);
    tk(); #1 chk("R8 no irq before hit", {31'b0, irq_o}, 32'h0);
    tk(); #1 chk("R8 irq on hit", {31'b0, irq_o}, 32'h1);
    wr(5'h10, 32'h0); #1 chk("R8 irq off with enable", {31'b0, irq_o}, 32'h0);
    rd(5'h14, v); chk("R8 status kept", v, 32'h1);
    wr(5'h14, 32'h7);

    // R6 hit with enables off, R9 switch output
    wr(5'h00, 32'h8); wr(5'h0C, 32'h9);
    tk();
    rd(5'h14, v); chk("R6 cmp1 latch without enable", v, 32'h2);
    #1 chk("R9 onsw low without switch enable", {31'b0, onsw_o}, 32'h0);
    wr(5'h10, 32'h08); #1 chk("R9 onsw from cmp1", {31'b0, onsw_o}, 32'h1);
    wr(5'h10, 32'h00); #1 chk("R9 onsw low again", {31'b0, onsw_o}, 32'h0);
    wr(5'h10, 32'h80); #1 chk("R9 onsw force", {31'b0, onsw_o}, 32'h1);
    wr(5'h10, 32'h00); wr(5'h14, 32'h2);

    // R9 switch event status with compare 0
    wr(5'h10, 32'h40); wr(5'h00, 32'h20); wr(5'h08, 32'h21); wr(5'h10, 32'h04);
    tk();
    rd(5'h14, v); chk("R9 switch event bit", v, 32'h5);
    #1 chk("R9 onsw from cmp0", {31'b0, onsw_o}, 32'h1);
    chk("R8 irq needs enable", {31'b0, irq_o}, 32'h0);
    wr(5'h14, 32'h7);

    // R7 hit beats simultaneous clear
    wr(5'h08, 32'h22);
    wr(5'h14, 32'h1, 1'b1);
    rd(5'h14, v); chk("R7 set wins over clear", v, 32'h5);

    // R5 soft reset ignores counter writes and ticks
    wr(5'h10, 32'h10); wr(5'h00, 32'h55);
    rd(5'h00, v); chk("R5 write ignored", v, 32'h0);
    tk();
    rd(5'h00, v); chk("R5 tick ignored", v, 32'h0);

    summary();
    $finish;
  end
endmodule